// File: doc/BRIEF.md
# Quad Wiper Register SPI Slave

This block is the digital control core of a four-channel digital potentiometer. It acts as an SPI mode-0 slave on a single system clock. The SPI clock, chip select and data input are taken in through synchronizers, and their edges are detected in the system clock domain. The block holds four 8-bit wiper codes and one 8-bit control register. It presents the wiper codes, a shutdown flag and the drive controls for the serial data output to the analog side.

A command is a pair of bytes. The first byte carries a 3-bit opcode in bits [7:5] and a 5-bit register address in bits [4:0]. The second byte carries data. Writes are held until chip select rises, and then the last 16 bits received are applied.

A read takes four bytes. The block answers during bytes three and four with an echo byte, `111` followed by the address, and then with the register value. Every bit received leaves the serial output exactly 16 bit-times later, so several devices can share one chip select in a chain. The output drives either push-pull or open-drain, as selected by a control bit.

Top module: `quad_wiper_spi`

## Requirements
- R1: After reset every wiper code is 80h and the control register is 40h, so shutdown is off and the output is push-pull.
- R2: Opcode 110 with address 00h..03h loads the data byte into that wiper, and the wiper output changes only after chip select rises.
- R3: Opcode 011 (address ignored), or opcode 110 at address 10h, writes the control register. Only bit 6 and bit 1 are stored, and every other bit reads as 0.
- R4: `shutdown_o` is 1 exactly while control bit 6 is 0. Entering or leaving shutdown leaves the stored wiper codes unchanged.
- R5: In a 4-byte read, SDO returns {111b, address} during byte 3 and then the data during byte 4, MSB first. Opcode 100 reads the addressed register, and opcode 001 reads the control register.
- R6: A write to an address other than 00h..03h or 10h changes nothing. A read of such an address returns 00h.
- R7: At chip select rise, a frame with fewer than 16 bits, or with a bit count that is not a multiple of 8, is ignored.
- R8: The command applied is the last 16 bits of the frame. SDO repeats each received bit 16 bit-times later and outputs 0 for the first 16 bits of a frame.
- R9: While chip select is high, SDO is not driven. In push-pull mode (bit 1 = 0) a 1 is actively driven. In open-drain mode (bit 1 = 1) a 1 releases the line and a 0 drives it low.
- R10: SDO changes only after an SCK falling edge or the start of a frame, never while SCK is high.
- R11: After reset, no bit is taken until chip select has gone from high to low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| spi_sck | input | 1 | SPI clock, idle low |
| spi_csn | input | 1 | Active-low chip select |
| spi_sdi | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out value |
| sdo_oe_o | output | 1 | Serial data out drive enable |
| wiper_o | output | N_WIPERS*8 | Wiper codes, channel i in bits [8i+7:8i] |
| shutdown_o | output | 1 | All channels in shutdown |

## Verification
Some properties are checked by assertions on every cycle:
- Wiper codes and the shutdown flag hold steady except in the cycle a chip-select rise is seen.
- Reserved control bits stay zero.
- SDO is undriven outside a frame and never drives a 1 in open-drain mode.
- The output bit moves only on an SCK fall or at the start of a frame.

Other behaviour needs whole frames, so only the bench scenarios show it. This covers the read reply contents and their bit order, the 16-bit pass-through delay, the rejection of short or ragged frames, the last-pair-wins rule, unmapped addresses, and the need for a chip-select fall after reset.

// File: rtl/quad_wiper_spi.sv
module quad_wiper_spi #(
  parameter int         N_WIPERS    = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] CTRL_ADDR   = 5'h10,
  parameter logic [7:0] WIPER_INIT  = 8'h80,
  parameter logic [7:0] CTRL_INIT   = 8'h40
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  spi_sck,
  input  logic                  spi_csn,
  input  logic                  spi_sdi,
  output logic                  sdo_o,
  output logic                  sdo_oe_o,
  output logic [N_WIPERS*8-1:0] wiper_o,
  output logic                  shutdown_o
);

  localparam int               BYTE     = 8;
  localparam int               FRAME    = 2 * BYTE;
  localparam int               CNT_W    = $clog2(FRAME);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME - 1);
  localparam logic [7:0]       CTRL_MASK = 8'h42;
  localparam logic [2:0]       OP_CRD = 3'b001;
  localparam logic [2:0]       OP_CWR = 3'b011;
  localparam logic [2:0]       OP_RD  = 3'b100;
  localparam logic [2:0]       OP_WR  = 3'b110;
  localparam logic [2:0]       ECHO   = 3'b111;

  logic [SYNC_STAGES-1:0] sck_sy, cs_sy, sdi_sy;
  logic sck_d, cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy <= '0;
      cs_sy  <= '0;
      sdi_sy <= '0;
      sck_d  <= 1'b0;
      cs_d   <= 1'b0;
    end else begin
      sck_sy <= {sck_sy[SYNC_STAGES-2:0], spi_sck};
      cs_sy  <= {cs_sy[SYNC_STAGES-2:0], spi_csn};
      sdi_sy <= {sdi_sy[SYNC_STAGES-2:0], spi_sdi};
      sck_d  <= sck_sy[SYNC_STAGES-1];
      cs_d   <= cs_sy[SYNC_STAGES-1];
    end
  end

  wire sck_s    = sck_sy[SYNC_STAGES-1];
  wire cs_s     = cs_sy[SYNC_STAGES-1];
  wire sdi_s    = sdi_sy[SYNC_STAGES-1];
  wire sck_rise = sck_s & ~sck_d;
  wire sck_fall = ~sck_s & sck_d;
  wire cs_fall  = ~cs_s & cs_d;
  wire cs_rise  = cs_s & ~cs_d;

  logic             active, got_pair, sdo_q;
  logic [CNT_W-1:0] bit_cnt;
  logic [FRAME-1:0] rx, tx;
  logic [7:0]       acr;
  logic [7:0]       wr [N_WIPERS];

  // read decode looks at the pair as it completes
  wire [FRAME-1:0] rx_next = {rx[FRAME-2:0], sdi_s};
  wire [2:0]       rd_op   = rx_next[15:13];
  wire [4:0]       rd_ad   = rx_next[12:8];
  wire             is_read = (rd_op == OP_CRD) || (rd_op == OP_RD);
  logic [7:0]      rd_data;

  always_comb begin
    rd_data = '0;
    if (rd_op == OP_CRD) rd_data = acr;
    else if (rd_op == OP_RD) begin
      if (rd_ad == CTRL_ADDR) rd_data = acr;
      for (int i = 0; i < N_WIPERS; i++)
        if (rd_ad == 5'(i)) rd_data = wr[i];
    end
  end

  wire [FRAME-1:0] reply = {ECHO, rd_ad, rd_data};

  // commit decode uses the last 16 bits held at chip select rise
  wire [2:0] cm_op     = rx[15:13];
  wire [4:0] cm_ad     = rx[12:8];
  wire [7:0] cm_dat    = rx[7:0];
  wire       commit_ok = active && got_pair && (bit_cnt[2:0] == 3'd0);
  wire       ctrl_we   = (cm_op == OP_CWR) || ((cm_op == OP_WR) && (cm_ad == CTRL_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      got_pair <= 1'b0;
      bit_cnt  <= '0;
      rx       <= '0;
      tx       <= '0;
      sdo_q    <= 1'b0;
      acr      <= CTRL_INIT;
      for (int i = 0; i < N_WIPERS; i++) wr[i] <= WIPER_INIT;
    end else if (cs_fall) begin
      active   <= 1'b1;
      got_pair <= 1'b0;
      bit_cnt  <= '0;
      rx       <= '0;
      tx       <= '0;
      sdo_q    <= 1'b0;
    end else if (cs_rise) begin
      active <= 1'b0;
      if (commit_ok) begin
        if (ctrl_we) acr <= cm_dat & CTRL_MASK;
        if (cm_op == OP_WR)
          for (int i = 0; i < N_WIPERS; i++)
            if (cm_ad == 5'(i)) wr[i] <= cm_dat;
      end
    end else if (active) begin
      if (sck_rise) begin
        rx      <= rx_next;
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == LAST_BIT) got_pair <= 1'b1;
        tx <= (bit_cnt == LAST_BIT && is_read) ? reply : {tx[FRAME-2:0], sdi_s};
      end
      if (sck_fall) sdo_q <= tx[FRAME-1];
    end
  end

  for (genvar g = 0; g < N_WIPERS; g++) begin : g_out
    assign wiper_o[g*8 +: 8] = wr[g];
  end

  wire od_mode = acr[1];
  assign shutdown_o = ~acr[6];
  assign sdo_oe_o   = active & (~od_mode | ~sdo_q);
  assign sdo_o      = od_mode ? 1'b0 : sdo_q;

  a_r2_wiper_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> $stable(wiper_o));

  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acr & ~CTRL_MASK) == 8'h00);

  a_r4_shdn_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> $stable(shutdown_o));

  a_r9_idle_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && cs_d) |-> !sdo_oe_o);

  a_r9_od_no_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe_o && od_mode) |-> !sdo_o);

  a_r10_sdo_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !(sck_fall || cs_fall) |=> $stable(sdo_q));

endmodule

// File: tb/quad_wiper_spi_tb.sv
module quad_wiper_spi_tb;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sck = 1'b0, spi_csn = 1'b1, spi_sdi = 1'b0;
  logic sdo_o, sdo_oe_o, shutdown_o;
  logic [31:0] wiper_o;

  quad_wiper_spi u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_csn(spi_csn), .spi_sdi(spi_sdi),
    .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .wiper_o(wiper_o), .shutdown_o(shutdown_o)
  );

  always #4 clk = ~clk;

  int total = 0, bad = 0, glitches = 0, undriven = 0;
  logic [31:0] rx_bits;
  logic [7:0] exp_w [4];

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic line();
    return sdo_oe_o ? sdo_o : 1'b1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic spi_open();
    rx_bits = '0;
    undriven = 0;
    spi_csn = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic spi_bits(input logic [31:0] din, input int n);
    for (int i = 0; i < n; i++) begin
      logic s;
      spi_sdi = din[n-1-i];
      wait_clk(HALF);
      s = line();
      if (s && !sdo_oe_o) undriven++;
      rx_bits = {rx_bits[30:0], s};
      spi_sck = 1'b1;
      wait_clk(HALF);
      if (line() !== s) glitches++;
      spi_sck = 1'b0;
    end
  endtask

  task automatic spi_close();
    wait_clk(HALF);
    spi_csn = 1'b1;
    spi_sdi = 1'b0;
    wait_clk(8);
  endtask

  task automatic frame(input logic [31:0] din, input int n);
    spi_open();
    spi_bits(din, n);
    spi_close();
  endtask

  task automatic read_reg(input logic [7:0] instr, output logic [15:0] reply);
    frame({instr, 24'h000000}, 32);
    reply = rx_bits[15:0];
  endtask

  function automatic logic [31:0] exp_wipers();
    return {exp_w[3], exp_w[2], exp_w[1], exp_w[0]};
  endfunction

  task automatic t_no_start();
    spi_csn = 1'b0;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    spi_bits({16'hC001, 16'h0000}, 16);
    chk("R11 no drive without frame start", {31'b0, sdo_oe_o}, 32'h0);
    spi_csn = 1'b1;
    wait_clk(8);
    chk("R11 write before first select fall ignored", wiper_o, 32'h80808080);
  endtask

  task automatic t_reset();
    logic [15:0] r;
    chk("R1 wiper reset", wiper_o, 32'h80808080);
    chk("R1 shutdown off", {31'b0, shutdown_o}, 32'h0);
    chk("R9 idle undriven", {31'b0, sdo_oe_o}, 32'h0);
    read_reg(8'h20, r);
    chk("R1 control reset value", {16'h0, r}, 32'h0000E040);
  endtask

  task automatic t_write();
    spi_open();
    spi_bits(32'h0000C13C, 16);
    wait_clk(2 * HALF);
    chk("R2 no change before select rise", wiper_o, exp_wipers());
    spi_close();
    exp_w[1] = 8'h3C;
    chk("R2 wiper1 written", wiper_o, exp_wipers());
    frame(32'h0000C000, 16); exp_w[0] = 8'h00;
    frame(32'h0000C2FF, 16); exp_w[2] = 8'hFF;
    frame(32'h0000C3A5, 16); exp_w[3] = 8'hA5;
    chk("R2 all wipers", wiper_o, exp_wipers());
  endtask

  task automatic t_read();
    logic [15:0] r;
    for (int a = 0; a < 4; a++) begin
      read_reg(8'h80 | 8'(a), r);
      chk("R5 read echo and data", {16'h0, r}, {16'h0, 3'b111, 5'(a), exp_w[a]});
    end
    chk("R8 first 16 output bits are zero", {16'h0, rx_bits[31:16]}, 32'h0);
    read_reg(8'h90, r);
    chk("R5 read control at 10h", {16'h0, r}, 32'h0000F040);
  endtask

  task automatic t_ctrl();
    logic [15:0] r;
    frame(32'h000067FF, 16);
    read_reg(8'h90, r);
    chk("R3 reserved bits read 0", {16'h0, r}, 32'h0000F042);
    frame(32'h0000D000, 16);
    read_reg(8'h20, r);
    chk("R3 control write at 10h", {16'h0, r}, 32'h0000E000);
    chk("R4 shutdown asserted", {31'b0, shutdown_o}, 32'h1);
    chk("R4 wipers kept in shutdown", wiper_o, exp_wipers());
    frame(32'h0000C277, 16); exp_w[2] = 8'h77;
    chk("R4 wiper write during shutdown", wiper_o, exp_wipers());
    frame(32'h00006040, 16);
    chk("R4 shutdown released", {31'b0, shutdown_o}, 32'h0);
    chk("R4 wipers restored", wiper_o, exp_wipers());
  endtask

  task automatic t_unmapped();
    logic [15:0] r;
    frame(32'h0000C511, 16);
    chk("R6 unmapped write wipers", wiper_o, exp_wipers());
    read_reg(8'h20, r);
    chk("R6 unmapped write control", {16'h0, r}, 32'h0000E040);
    read_reg(8'h85, r);
    chk("R6 unmapped read zero", {16'h0, r}, 32'h0000E500);
  endtask

  task automatic t_bad_frames();
    frame(32'h00000C01, 12);
    chk("R7 12-bit frame ignored", wiper_o, exp_wipers());
    frame(32'h000000C0, 8);
    chk("R7 8-bit frame ignored", wiper_o, exp_wipers());
    frame(32'h000FC055, 20);
    chk("R7 20-bit frame ignored", wiper_o, exp_wipers());
    frame(32'h00FFC055, 24); exp_w[0] = 8'h55;
    chk("R8 last 16 of 24 bits applied", wiper_o, exp_wipers());
  endtask

  task automatic t_daisy();
    frame(32'hC011C399, 32); exp_w[3] = 8'h99;
    chk("R8 last pair wins", wiper_o, exp_wipers());
    chk("R8 pass-through after 16 bits", rx_bits, 32'h0000C011);
  endtask

  task automatic t_drive();
    logic [15:0] r;
    read_reg(8'h83, r);
    chk("R9 push-pull ones driven", undriven, 0);
    frame(32'h00006002, 16);
    read_reg(8'h83, r);
    chk("R9 open-drain read through pull-up", {16'h0, r}, {16'h0, 3'b111, 5'd3, exp_w[3]});
    total++;
    if (undriven == 0) begin
      bad++;
      $display("FAIL R9 open-drain ones released actual=%0d expected>0", undriven);
    end
    frame(32'h00006040, 16);
    chk("R10 no SDO change while SCK high", glitches, 0);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) exp_w[i] = 8'h80;
    wait_clk(3);
    t_no_start();
    t_reset();
    t_write();
    t_read();
    t_ctrl();
    t_unmapped();
    t_bad_frames();
    t_daisy();
    t_drive();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule